// File: doc/BRIEF.md
# Priority Crossbar Pin Allocator

The allocator places the signals of a fixed set of digital peripheral groups onto a bank of general-purpose pins. The default bank is four ports of eight pins each, so 32 pins. Each group has its own enable bit, and one master switch turns the whole crossbar on or off. The enabled groups are packed one after another onto the lowest free pins, in a fixed group priority. A group's pin positions therefore move when a group ranked above it is switched on or off. Every pin that no group claims stays an ordinary I/O pin and follows its port latch.

The enable bits are captured on the clock edge. The pin map is then derived combinationally from the captured values. Pin outputs, pin output enables and the signals returned to the peripherals follow the live inputs within the same cycle. The data read path of each port always shows the real pin level, whether the pin is claimed or not.

Top module: `pin_crossbar`

## Requirements
- R1: `cfg_grp_en` and `cfg_xbar_en` are captured on each rising clock edge. A change on them alters the pin map only after the next edge, and not before it.
- R2: While the captured master switch is 0, every pin acts as general I/O and every bit of `sig_in` is 1.
- R3: The groups are allocated by enable bit, starting with bit 0 as the highest rank, and their widths are: bit0 serial-A 2, bit1 SPI 4, bit2 I2C 2, bit3 serial-B 2, bit4 capture/PWM 6, bit5 comparator 2, bit6 timer/interrupt 8, bit7 clock-out 1, bit8 convert-start 1. Each enabled group takes the next consecutive free pins, starting at pin 0, and a disabled group takes none.
- R4: No pin is claimed by more than one signal. An unclaimed pin has `pin_out` equal to its latch bit and `pin_oe` equal to the inverse of that latch bit, which gives open-drain behaviour.
- R5: The signals are numbered in group order, with the lowest offset first, from 0 to 27. Signals 1, 3, 5, 9, 18 to 25 and 27 are inputs, and all the others are outputs. A pin claimed by an output signal has `pin_oe` = 1 and `pin_out` equal to that signal's `sig_out` bit.
- R6: A pin claimed by an input signal has `pin_oe` = 0 and `pin_out` = 0, and that signal's `sig_in` bit equals the level of the pin.
- R7: The `sig_in` bit of an output-class signal, or of a signal whose group is not placed, is 1, which is the idle level.
- R8: A group that does not fit in the pins left over is not placed at all, and it consumes no pins. The groups ranked below it continue from the same next free pin.
- R9: `port_rd` always equals `pin_in`.
- R10: A clocked reset with `rst_n` low clears the captured enables, so every pin reverts to general I/O.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_xbar_en | input | 1 | Master crossbar switch |
| cfg_grp_en | input | 9 | Per-group enable bits, with bit 0 as the highest rank |
| gpio_latch | input | NUM_PORTS*PORT_W | Port latch values, pin 0 in bit 0 |
| pin_in | input | NUM_PORTS*PORT_W | Live pin levels |
| sig_out | input | 28 | Values driven by the peripheral signals |
| pin_out | output | NUM_PORTS*PORT_W | Output value for each pin |
| pin_oe | output | NUM_PORTS*PORT_W | Output enable for each pin |
| sig_in | output | 28 | Pin levels returned to the peripheral signals |
| port_rd | output | NUM_PORTS*PORT_W | Port data read value, which is the live pin level |

## Verification
The packing is first exercised with a sparse enable pattern that leaves the top-ranked groups off. This shows that a lower group slides down to pin 0 instead of keeping a fixed slot. A fully enabled pattern is applied to both a 32-pin and a 24-pin instance. It separates the case where everything fits from the case where the timer group overflows and the single-pin groups move in ahead of it. Random enable, latch, pin and peripheral patterns then mix output pins, input pins and open-drain general I/O pins in every cycle. A per-cycle model finds which one of these each pin should be, and a driver picked from the wrong class shows up as a mismatch.

// File: rtl/xbar_pkg.sv
// Package: shared constants for the pin crossbar.
// Describes the group widths in priority order, the signal numbering and
// the direction class of each signal. It assumes the signals are numbered
// in group order, with the lowest offset first.
package xbar_pkg;

    localparam int NGRP = 9;
    localparam int NSIG = 28;

    // Width of each group, with index 0 as the highest rank
    localparam int GRP_W [NGRP] = '{2, 4, 2, 2, 6, 2, 8, 1, 1};

    // 1 = input-class signal (pin level goes to the peripheral)
    localparam logic [NSIG-1:0] SIG_IS_INPUT = 28'h0BFC022A;

    // First signal index of group g
    function automatic int grp_first(int g);
        int acc;
        acc = 0;
        for (int i = 0; i < g; i++) acc += GRP_W[i];
        return acc;
    endfunction

    // Group that owns signal s
    function automatic int sig_group(int s);
        int grp;
        grp = 0;
        for (int i = 0; i < NGRP; i++)
            if (s >= grp_first(i)) grp = i;
        return grp;
    endfunction

    // Offset of signal s inside its group
    function automatic int sig_offset(int s);
        return s - grp_first(sig_group(s));
    endfunction

endpackage

// File: rtl/xbar_cfg_reg.sv
// Module: xbar_cfg_reg
// Captures the group enables and the master switch on the clock.
// Assumes a synchronous active-low reset, which clears all enables.
module xbar_cfg_reg #(
    parameter int NGRP = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_xbar_en,
    input  logic [NGRP-1:0] cfg_grp_en,
    output logic            xbar_q,
    output logic [NGRP-1:0] en_q
);

    // Capture the configuration on each edge; reset turns everything off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xbar_q <= 1'b0;
            en_q   <= '0;
        end else begin
            xbar_q <= cfg_xbar_en;
            en_q   <= cfg_grp_en;
        end
    end

    // R1: the value captured is the one presented one cycle earlier
    a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (en_q == $past(cfg_grp_en)) && (xbar_q == $past(cfg_xbar_en)));

endmodule

// File: rtl/xbar_alloc.sv
// Module: xbar_alloc
// Walks the groups in rank order with a running cursor. It gives each
// enabled group that fits the next consecutive pins, then yields the pin
// and a valid flag for every signal. Assumes that NPINS is at least 2.
module xbar_alloc
    import xbar_pkg::*;
#(
    parameter int NPINS = 32,
    localparam int PW   = $clog2(NPINS),
    localparam int IW   = $clog2(NPINS + NSIG + 1)
) (
    input  logic                     xbar_q,
    input  logic [NGRP-1:0]          en_q,
    output logic [NSIG-1:0]          sig_valid,
    output logic [NSIG-1:0][PW-1:0]  sig_pin,
    output logic [IW-1:0]            claim_total
);

    logic [PW-1:0]   base [NGRP];
    logic [NGRP-1:0] fit;
    logic [IW-1:0]   cur;

    // Prefix walk: place each group that is enabled and fits, then advance the cursor
    always_comb begin
        cur = '0;
        for (int g = 0; g < NGRP; g++) begin
            base[g] = cur[PW-1:0];
            fit[g]  = xbar_q && en_q[g] && ((cur + IW'(GRP_W[g])) <= IW'(NPINS));
            if (fit[g]) cur = cur + IW'(GRP_W[g]);
        end
        claim_total = cur;
    end

    // Map each signal to its group's base pin plus its offset
    for (genvar s = 0; s < NSIG; s++) begin : g_sig
        localparam int G   = sig_group(s);
        localparam int OFF = sig_offset(s);
        assign sig_valid[s] = fit[G];
        assign sig_pin[s]   = base[G] + PW'(OFF);
    end

endmodule

// File: rtl/xbar_pin_mux.sv
// Module: xbar_pin_mux
// Per pin: finds the signal that claims the pin and selects the driver.
// An output signal drives the pin, an input signal releases it, and an
// unclaimed pin follows its latch as open drain. Assumes the signal map
// comes from xbar_alloc.
module xbar_pin_mux
    import xbar_pkg::*;
#(
    parameter int NPINS = 32,
    localparam int PW   = $clog2(NPINS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NSIG-1:0]          sig_valid,
    input  logic [NSIG-1:0][PW-1:0]  sig_pin,
    input  logic [NSIG-1:0]          sig_out,
    input  logic [NPINS-1:0]         gpio_latch,
    output logic [NPINS-1:0]         pin_out,
    output logic [NPINS-1:0]         pin_oe,
    output logic [NPINS-1:0]         pin_owned
);

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic [NSIG-1:0] claim;

        // Claim vector: which signals sit on this pin
        for (genvar s = 0; s < NSIG; s++) begin : g_claim
            assign claim[s] = sig_valid[s] && (sig_pin[s] == PW'(p));
        end

        // Driver select: peripheral output, released input, or open-drain latch
        assign pin_owned[p] = |claim;
        assign pin_out[p]   = pin_owned[p] ? |(claim & ~SIG_IS_INPUT & sig_out) : gpio_latch[p];
        assign pin_oe[p]    = pin_owned[p] ? |(claim & ~SIG_IS_INPUT) : ~gpio_latch[p];

        // R4: at most one signal owns a pin
        a_r4_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(claim));
    end

endmodule

// File: rtl/xbar_in_route.sv
// Module: xbar_in_route
// Returns pin levels to the input-class peripheral signals. Output-class
// and unplaced signals read the idle level, which is 1.
module xbar_in_route
    import xbar_pkg::*;
#(
    parameter int NPINS = 32,
    localparam int PW   = $clog2(NPINS)
) (
    input  logic [NSIG-1:0]          sig_valid,
    input  logic [NSIG-1:0][PW-1:0]  sig_pin,
    input  logic [NPINS-1:0]         pin_in,
    output logic [NSIG-1:0]          sig_in
);

    // Per signal: select the pin level when placed and input-class, else idle
    for (genvar s = 0; s < NSIG; s++) begin : g_route
        assign sig_in[s] = (SIG_IS_INPUT[s] && sig_valid[s]) ? pin_in[sig_pin[s]] : 1'b1;
    end

endmodule

// File: rtl/pin_crossbar.sv
// Module: pin_crossbar (top)
// A priority crossbar that packs the enabled peripheral groups onto
// NUM_PORTS ports of PORT_W pins each. It registers the configuration,
// computes the placement, then muxes the pins and routes the inputs.
// Assumes a synchronous active-low reset.
module pin_crossbar
    import xbar_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 8,
    localparam int NPINS    = NUM_PORTS * PORT_W,
    localparam int PW       = $clog2(NPINS),
    localparam int IW       = $clog2(NPINS + NSIG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_xbar_en,
    input  logic [NGRP-1:0]   cfg_grp_en,
    input  logic [NPINS-1:0]  gpio_latch,
    input  logic [NPINS-1:0]  pin_in,
    input  logic [NSIG-1:0]   sig_out,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NSIG-1:0]   sig_in,
    output logic [NPINS-1:0]  port_rd
);

    logic                    xbar_q;
    logic [NGRP-1:0]         en_q;
    logic [NSIG-1:0]         sig_valid;
    logic [NSIG-1:0][PW-1:0] sig_pin;
    logic [IW-1:0]           claim_total;
    logic [NPINS-1:0]        pin_owned;

    xbar_cfg_reg #(.NGRP(NGRP)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_xbar_en(cfg_xbar_en), .cfg_grp_en(cfg_grp_en),
        .xbar_q(xbar_q), .en_q(en_q)
    );

    xbar_alloc #(.NPINS(NPINS)) u_alloc (
        .xbar_q(xbar_q), .en_q(en_q),
        .sig_valid(sig_valid), .sig_pin(sig_pin), .claim_total(claim_total)
    );

    xbar_pin_mux #(.NPINS(NPINS)) u_mux (
        .clk(clk), .rst_n(rst_n),
        .sig_valid(sig_valid), .sig_pin(sig_pin), .sig_out(sig_out),
        .gpio_latch(gpio_latch),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_owned(pin_owned)
    );

    xbar_in_route #(.NPINS(NPINS)) u_route (
        .sig_valid(sig_valid), .sig_pin(sig_pin), .pin_in(pin_in), .sig_in(sig_in)
    );

    // Port read path: always the live pin level
    assign port_rd = pin_in;

    // R2: with the master switch off, pins are open-drain I/O and inputs idle
    a_r2_off_gpio: assert property (@(posedge clk) disable iff (!rst_n)
        !xbar_q |-> (pin_oe == ~gpio_latch) && (&sig_in));

    // R3: pins owned by the mux match the cursor total from the allocator
    a_r3_claim_count: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pin_owned) == int'(claim_total));

endmodule

// File: tb/test_pin_crossbar.sv
`timescale 1ns/1ps
module test_pin_crossbar;

    localparam int NSIG = 28;
    localparam int NGRP = 9;
    localparam logic [NSIG-1:0] IS_IN = 28'h0BFC022A;
    localparam int GW [NGRP] = '{2, 4, 2, 2, 6, 2, 8, 1, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_xbar_en = 1'b0;
    logic [NGRP-1:0] cfg_grp_en = '0;
    logic [31:0] latch = '0;
    logic [31:0] pins = '0;
    logic [NSIG-1:0] sout = '0;

    logic [31:0] po_a, poe_a, rd_a;
    logic [NSIG-1:0] si_a;
    logic [23:0] po_b, poe_b, rd_b;
    logic [NSIG-1:0] si_b;

    int n_tests = 0;
    int n_fail = 0;
    logic m_xb = 1'b0;
    logic [NGRP-1:0] m_en = '0;

    always #10 clk = ~clk;

    pin_crossbar i_pin_crossbar (
        .clk(clk), .rst_n(rst_n), .cfg_xbar_en(cfg_xbar_en), .cfg_grp_en(cfg_grp_en),
        .gpio_latch(latch), .pin_in(pins), .sig_out(sout),
        .pin_out(po_a), .pin_oe(poe_a), .sig_in(si_a), .port_rd(rd_a)
    );

    pin_crossbar #(.NUM_PORTS(3)) i_pin_crossbar_small (
        .clk(clk), .rst_n(rst_n), .cfg_xbar_en(cfg_xbar_en), .cfg_grp_en(cfg_grp_en),
        .gpio_latch(latch[23:0]), .pin_in(pins[23:0]), .sig_out(sout),
        .pin_out(po_b), .pin_oe(poe_b), .sig_in(si_b), .port_rd(rd_b)
    );

    // Reference copy of the captured configuration
    always @(posedge clk) begin
        if (!rst_n) begin m_xb <= 1'b0; m_en <= '0; end
        else begin m_xb <= cfg_xbar_en; m_en <= cfg_grp_en; end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h @%0t", tag, what, act, exp, $time);
        end
    endtask

    // Behavioural model of one instance with np pins, compared against its outputs
    task automatic cmp_inst(input int np, input logic [31:0] po, input logic [31:0] poe,
                            input logic [NSIG-1:0] si, input string nm);
        int own [32];
        int spin [NSIG];
        bit unfit [NGRP];
        int cur = 0;
        int sidx = 0;
        for (int p = 0; p < 32; p++) own[p] = -1;
        for (int s = 0; s < NSIG; s++) spin[s] = -1;
        for (int g = 0; g < NGRP; g++) begin
            unfit[g] = 1'b0;
            if (m_xb && m_en[g]) begin
                if (cur + GW[g] <= np) begin
                    for (int k = 0; k < GW[g]; k++) begin
                        own[cur + k] = sidx + k;
                        spin[sidx + k] = cur + k;
                    end
                    cur += GW[g];
                end else unfit[g] = 1'b1;
            end
            sidx += GW[g];
        end
        for (int p = 0; p < np; p++) begin
            logic eo, eoe;
            string tag;
            if (own[p] < 0) begin
                eo = latch[p]; eoe = ~latch[p];
                tag = !rst_n ? "R10" : (!m_xb ? "R2" : "R4");
            end else if (IS_IN[own[p]]) begin
                eo = 1'b0; eoe = 1'b0; tag = "R6";
            end else begin
                eo = sout[own[p]]; eoe = 1'b1; tag = "R5";
            end
            chk(po[p] === eo && poe[p] === eoe, tag, $sformatf("%s pin %0d out/oe", nm, p),
                {30'd0, po[p], poe[p]}, {30'd0, eo, eoe});
        end
        sidx = 0;
        for (int g = 0; g < NGRP; g++) begin
            for (int k = 0; k < GW[g]; k++) begin
                int s = sidx + k;
                logic e;
                string tag;
                if (spin[s] >= 0 && IS_IN[s]) begin e = pins[spin[s]]; tag = "R6"; end
                else begin e = 1'b1; tag = unfit[g] ? "R8" : (!m_xb ? "R2" : "R7"); end
                chk(si[s] === e, tag, $sformatf("%s sig_in %0d", nm, s),
                    {31'd0, si[s]}, {31'd0, e});
            end
            sidx += GW[g];
        end
    endtask

    task automatic compare_all();
        cmp_inst(32, po_a, poe_a, si_a, "A");
        cmp_inst(24, {8'd0, po_b}, {8'd0, poe_b}, si_b, "B");
        chk(rd_a === pins && rd_b === pins[23:0], "R9", "port_rd", rd_a, pins);
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        latch = 32'hA5A5_0F0F; pins = 32'h3C3C_F00F; sout = 28'hFFFFFFF;
        cfg_xbar_en = 1'b1; cfg_grp_en = '1;
        cycle(); cycle();
        // R10: while in reset every pin is open-drain I/O
        chk(poe_a === ~latch && po_a === latch, "R10", "reset pins", poe_a, ~latch);
        rst_n = 1'b1;
        cfg_xbar_en = 1'b0;
        cycle(); cycle();

        // R3: only serial-B and capture/PWM enabled, so serial-B slides to pin 0
        cfg_xbar_en = 1'b1; cfg_grp_en = 9'b0_0001_1000;
        sout = 28'h0; sout[8] = 1'b1; sout[12] = 1'b1;
        pins = 32'h0000_0002;
        #2;
        // R1: nothing changes before the capturing edge
        chk(poe_a === ~latch, "R1", "map before edge", poe_a, ~latch);
        cycle();
        chk(poe_a[7:0] === 8'hFD, "R3", "oe pins 0..7", {24'd0, poe_a[7:0]}, 32'hFD);
        chk(po_a[0] === 1'b1 && po_a[4] === 1'b1 && po_a[3] === 1'b0, "R3", "pin values",
            {29'd0, po_a[0], po_a[4], po_a[3]}, 32'h6);
        chk(si_a[9] === 1'b1, "R6", "serial-B rx from pin 1", {31'd0, si_a[9]}, 32'h1);

        // R8: all enabled, the timer group overflows the 24-pin instance
        cfg_grp_en = '1; pins = 32'h0000_0000; sout = '0; sout[26] = 1'b1;
        cycle();
        chk(si_b[18] === 1'b1, "R8", "timer input idle", {31'd0, si_b[18]}, 32'h1);
        chk(poe_b[18] === 1'b1 && po_b[18] === 1'b1, "R8", "clock-out on pin 18",
            {30'd0, poe_b[18], po_b[18]}, 32'h3);
        chk(poe_b[19] === 1'b0 && si_b[27] === 1'b0, "R8", "convert-start on pin 19",
            {30'd0, poe_b[19], si_b[27]}, 32'h0);
        chk(poe_a[26] === 1'b1 && si_a[18] === 1'b0, "R3", "full fit on 32 pins",
            {30'd0, poe_a[26], si_a[18]}, 32'h2);

        // Random patterns: configuration, latches, pins and peripheral outputs
        for (int i = 0; i < 400; i++) begin
            cfg_xbar_en = ($urandom_range(0, 7) != 0);
            cfg_grp_en  = NGRP'($urandom);
            latch = $urandom; pins = $urandom; sout = NSIG'($urandom);
            if (i % 50 == 7) rst_n = 1'b0; else rst_n = 1'b1;
            cycle();
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule